// File: doc/BRIEF.md
# Digit-Serial Redundant-Basis Field Multiplier

This block multiplies two elements of a binary extension field that are held as redundant-basis vectors of N bits. In this representation, multiplying by the basis element is a circular rotation of the vector. The field product of A and B is therefore the XOR of rotated copies of A, one copy for each set bit of B. No modular reduction step is needed.

Operand A is captured in parallel when a start is accepted. Operand B is consumed D bits per clock, least significant digit first. In each cycle, D rotated copies of a running copy of A are gated by the digit bits and XOR-reduced. The sum is then folded into an N-bit accumulator. After every digit has drained through the pipeline, a one-cycle completion pulse marks the product as valid.

Two parameters place extra registers in the datapath:
- One adds a register between the gating stage and the XOR stage, so that AND and XOR work concurrently in separate stages.
- The other places a register after every level of the XOR tree.

Both trade latency for a shorter clock period. Conversion to or from a polynomial basis is not part of the block.

Top module: `rbm_digit_mult`

## Requirements
- R1: While reset is low and in the first cycle after its release, busy, done and p_out are all zero.
- R2: The completed product equals the XOR, over every bit position i with b_in[i]=1, of a_in rotated left by i positions. Bit j of the operand moves to bit (j+i) mod N.
- R3: done is high for exactly one cycle per accepted start. It rises N/D + AND_REG + TREE_REG*ceil(log2 D) cycles after the clock edge that accepted start.
- R4: busy is high from the cycle after an accepted start until done rises, and busy is never high in the same cycle as done.
- R5: A start asserted while busy is high is ignored: the running product is neither restarted nor altered by the new operands.
- R6: While the block is idle and start is low, p_out holds its value.
- R7: An accepted start clears the accumulator, so p_out reads zero in the cycle after the accepting edge.
- R8: Every setting of AND_REG and TREE_REG and every legal D yields the same product for the same operands. Only the latency differs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication; accepted only while busy is low |
| a_in | input | N | Parallel operand, captured on the accepting edge |
| b_in | input | N | Serial operand, captured on the accepting edge and consumed D bits per cycle |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse: p_out holds the finished product |
| p_out | output | N | Accumulated redundant-basis product |

## Verification
The bench builds two instances side by side from the same inputs, both with N=16:
- The first uses D=2 with no optional registers. It gives a shallow, purely combinational reduction and a latency of 8.
- The second uses D=4 with both the gating register and the per-level tree registers enabled. Its latency is 7, and its two-level registered XOR tree has a four-stage path.

Comparing the two instances covers both ends of the latency formula and the tree pipelining. It also shows that the digit order and rotation amount are independent of the variant. A start pulse with different operands in the middle of a run is used to show that the running product is left alone.

// File: rtl/rbm_pkg.sv
package rbm_pkg;

   // Side information travelling with each digit through the pipeline.
   typedef struct packed {
      logic vld;   // stage holds a live digit
      logic last;  // digit is the final one of the operand
   } rbm_tag_t;

   // Number of XOR tree levels needed to fold d vectors into one.
   function automatic int unsigned rbm_levels(input int unsigned d);
      int unsigned lv;
      lv = 0;
      while ((1 << lv) < d) lv++;
      return lv;
   endfunction

   // Cycles from the accepting edge to the rising edge of done.
   function automatic int unsigned rbm_latency(input int unsigned n, input int unsigned d,
                                               input bit and_reg, input bit tree_reg);
      return (n / d) + (and_reg ? 1 : 0) + (tree_reg ? rbm_levels(d) : 0);
   endfunction

endpackage

// File: rtl/rbm_ppg.sv
// Partial-product generation: D rotated copies of the running operand,
// each gated by one bit of the current digit. Optional output register.
module rbm_ppg
   import rbm_pkg::*;
#(
   parameter int unsigned N   = 16,
   parameter int unsigned D   = 2,
   parameter bit          REG = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   a_rot,
   input  logic [D-1:0]   digit,
   input  rbm_tag_t       tag_in,
   output logic [D*N-1:0] terms,
   output rbm_tag_t       tag_out
);

   logic [D*N-1:0] raw;

   // Copy j is the operand rotated left by j; rotation is wiring only.
   for (genvar j = 0; j < D; j++) begin : g_copy
      for (genvar i = 0; i < N; i++) begin : g_bit
         localparam int unsigned SRC = (i + N - j) % N;
         assign raw[j*N + i] = a_rot[SRC] & digit[j];
      end
   end

   if (REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            terms   <= '0;
            tag_out <= '0;
         end else begin
            terms   <= raw;
            tag_out <= tag_in;
         end
      end
   end else begin : g_comb
      assign terms   = raw;
      assign tag_out = tag_in;
   end

   a_r8_tag_last_live: assert property (@(posedge clk) disable iff (!rst_n)
      tag_out.last |-> tag_out.vld);

endmodule

// File: rtl/rbm_xor_tree.sv
// Binary XOR reduction of D vectors, optionally registered after each level.
module rbm_xor_tree
   import rbm_pkg::*;
#(
   parameter int unsigned N   = 16,
   parameter int unsigned D   = 2,
   parameter bit          REG = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [D*N-1:0] terms,
   input  rbm_tag_t       tag_in,
   output logic [N-1:0]   sum,
   output rbm_tag_t       tag_out
);

   localparam int unsigned LEVELS = rbm_levels(D);
   localparam int unsigned WIDE   = 1 << LEVELS;

   for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_lv
      logic [WIDE*N-1:0] bus;
      rbm_tag_t          tag;

      if (lv == 0) begin : g_in
         assign bus = (WIDE*N)'(terms);
         assign tag = tag_in;
      end else begin : g_red
         localparam int unsigned PAIRS = WIDE >> lv;
         logic [WIDE*N-1:0] nxt;

         always_comb begin
            nxt = '0;
            for (int k = 0; k < int'(PAIRS); k++) begin
               nxt[k*N +: N] = g_lv[lv-1].bus[(2*k)*N +: N] ^
                               g_lv[lv-1].bus[(2*k+1)*N +: N];
            end
         end

         if (REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  bus <= '0;
                  tag <= '0;
               end else begin
                  bus <= nxt;
                  tag <= g_lv[lv-1].tag;
               end
            end
         end else begin : g_comb
            assign bus = nxt;
            assign tag = g_lv[lv-1].tag;
         end
      end
   end

   assign sum     = g_lv[LEVELS].bus[N-1:0];
   assign tag_out = g_lv[LEVELS].tag;

   a_r3_tree_last_live: assert property (@(posedge clk) disable iff (!rst_n)
      tag_out.last |-> tag_out.vld);

endmodule

// File: rtl/rbm_acc.sv
// Add-accumulate stage: XOR-folds each digit sum into the result.
module rbm_acc
   import rbm_pkg::*;
#(
   parameter int unsigned N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [N-1:0] sum,
   input  rbm_tag_t     tag_in,
   output logic [N-1:0] acc,
   output logic         done
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         done <= 1'b0;
      end else begin
         done <= tag_in.vld & tag_in.last;
         if (clr)             acc <= '0;
         else if (tag_in.vld) acc <= acc ^ sum;
      end
   end

   a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // A live digit never coincides with a clear (R7).
   a_r7_no_clear_clash: assert property (@(posedge clk) disable iff (!rst_n)
      clr |-> !tag_in.vld);

endmodule

// File: rtl/rbm_digit_mult.sv
module rbm_digit_mult
   import rbm_pkg::*;
#(
   parameter int unsigned N        = 16,
   parameter int unsigned D        = 2,
   parameter bit          AND_REG  = 1'b0,
   parameter bit          TREE_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [N-1:0] a_in,
   input  logic [N-1:0] b_in,
   output logic         busy,
   output logic         done,
   output logic [N-1:0] p_out
);

   localparam int unsigned DIGITS = N / D;
   localparam int unsigned CW     = (DIGITS > 1) ? $clog2(DIGITS) : 1;
   localparam int unsigned LAT    = rbm_latency(N, D, AND_REG, TREE_REG);

   if (D == 0 || D > N || (N % D) != 0) begin : g_bad_digit
      $error("rbm_digit_mult: D must divide N and lie in 1..N");
   end
   if (LAT < 1) begin : g_bad_lat
      $error("rbm_digit_mult: latency must be at least one cycle");
   end

   logic [N-1:0]  a_rot_q, b_sh_q, a_rot_nx;
   logic [CW-1:0] cnt_q;
   logic          issue_q, busy_q, accept, final_dig, fin;
   rbm_tag_t      in_tag, pp_tag, sum_tag;
   logic [D*N-1:0] pp_terms;
   logic [N-1:0]   dig_sum;

   assign accept    = start & ~busy_q;
   assign final_dig = (cnt_q == CW'(DIGITS - 1));

   // Next digit's view of A: rotate left by D, pure wiring.
   for (genvar i = 0; i < N; i++) begin : g_rot
      localparam int unsigned SRC = (i + N - D) % N;
      assign a_rot_nx[i] = a_rot_q[SRC];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_rot_q <= '0;
         b_sh_q  <= '0;
         cnt_q   <= '0;
         issue_q <= 1'b0;
      end else if (accept) begin
         a_rot_q <= a_in;
         b_sh_q  <= b_in;
         cnt_q   <= '0;
         issue_q <= 1'b1;
      end else if (issue_q) begin
         a_rot_q <= a_rot_nx;
         b_sh_q  <= b_sh_q >> D;
         cnt_q   <= cnt_q + 1'b1;
         if (final_dig) issue_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_q <= 1'b0;
      else if (accept) busy_q <= 1'b1;
      else if (fin)    busy_q <= 1'b0;
   end

   assign in_tag.vld  = issue_q;
   assign in_tag.last = issue_q & final_dig;

   rbm_ppg #(.N(N), .D(D), .REG(AND_REG)) u_ppg (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_rot  (a_rot_q),
      .digit  (b_sh_q[D-1:0]),
      .tag_in (in_tag),
      .terms  (pp_terms),
      .tag_out(pp_tag)
   );

   rbm_xor_tree #(.N(N), .D(D), .REG(TREE_REG)) u_tree (
      .clk    (clk),
      .rst_n  (rst_n),
      .terms  (pp_terms),
      .tag_in (pp_tag),
      .sum    (dig_sum),
      .tag_out(sum_tag)
   );

   assign fin = sum_tag.vld & sum_tag.last;

   rbm_acc #(.N(N)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .sum   (dig_sum),
      .tag_in(sum_tag),
      .acc   (p_out),
      .done  (done)
   );

   assign busy = busy_q;

   a_r4_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r4_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   a_r7_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (p_out == '0));

   a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(p_out));

   a_r5_ignore_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy && issue_q && !final_dig) |=> issue_q);

   a_r1_digit_bound: assert property (@(posedge clk) disable iff (!rst_n)
      issue_q |-> (cnt_q <= CW'(DIGITS - 1)));

endmodule

// File: tb/rbm_digit_mult_tb.sv
module rbm_digit_mult_tb;

   localparam int N  = 16;
   localparam int L0 = 8;   // D=2, no optional registers: 8 digits
   localparam int L1 = 7;   // D=4, gate reg + 2 tree levels: 4+1+2

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [N-1:0] a_in = '0;
   logic [N-1:0] b_in = '0;
   logic         busy0, done0, busy1, done1;
   logic [N-1:0] p0, p1;

   always #4 clk = ~clk;   // 125 MHz

   rbm_digit_mult #(.N(N), .D(2), .AND_REG(1'b0), .TREE_REG(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
      .busy(busy0), .done(done0), .p_out(p0));

   rbm_digit_mult #(.N(N), .D(4), .AND_REG(1'b1), .TREE_REG(1'b1)) u_dut_pipe (
      .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
      .busy(busy1), .done(done1), .p_out(p1));

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
      logic [N-1:0] r;
      r = '0;
      for (int i = 0; i < N; i++)
         if (b[i]) r ^= (a << i) | (a >> (N - i));
      return r;
   endfunction

   // Completion monitors.
   int           sc = 0;
   int           dn0 = 0, dn1 = 0, lat0 = 0, lat1 = 0;
   logic [N-1:0] r0 = '0, r1 = '0;
   logic         bz0 = 1'b0, bz1 = 1'b0;

   always @(negedge clk) begin
      if (done0) begin dn0++; lat0 = cyc - sc - 1; r0 = p0; bz0 = busy0; end
      if (done1) begin dn1++; lat1 = cyc - sc - 1; r1 = p1; bz1 = busy1; end
   end

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   task automatic run(input logic [N-1:0] a, input logic [N-1:0] b, input bit inject);
      logic [N-1:0] exp;
      exp = ref_mul(a, b);
      @(negedge clk);
      a_in = a; b_in = b; start = 1'b1; sc = cyc; dn0 = 0; dn1 = 0;
      @(negedge clk);
      start = 1'b0;
      #1;
      chk("R7 clear dut0", p0, '0);
      chk("R7 clear dut1", p1, '0);
      chk("R4 busy dut0", N'(busy0), N'(1));
      chk("R4 busy dut1", N'(busy1), N'(1));
      if (inject) begin
         @(negedge clk);
         @(negedge clk);
         a_in = ~a; b_in = ~b ^ 16'h0101; start = 1'b1;   // R5: must be ignored
         @(negedge clk);
         start = 1'b0;
      end
      for (int t = 0; t < 40 && !(dn0 > 0 && dn1 > 0); t++) begin
         @(negedge clk);
         #1;
      end
      repeat (4) @(negedge clk);
      #1;
      chk(inject ? "R5 product dut0" : "R2 product dut0", r0, exp);
      chk(inject ? "R5 product dut1" : "R8 product dut1", r1, exp);
      chk("R3 latency dut0", N'(lat0), N'(L0));
      chk("R3 latency dut1", N'(lat1), N'(L1));
      chk("R3 one pulse dut0", N'(dn0), N'(1));
      chk("R3 one pulse dut1", N'(dn1), N'(1));
      chk("R4 busy low at done dut0", N'(bz0), N'(0));
      chk("R4 busy low at done dut1", N'(bz1), N'(0));
      chk("R6 hold dut0", p0, r0);
      chk("R6 hold dut1", p1, r1);
   endtask

   localparam int NV = 8;
   localparam logic [N-1:0] VA [NV] = '{16'h0000, 16'hFFFF, 16'h0001, 16'h0001,
                                        16'h8001, 16'hFFFF, 16'h1234, 16'h0000};
   localparam logic [N-1:0] VB [NV] = '{16'h0000, 16'hFFFF, 16'h0001, 16'h8000,
                                        16'h0003, 16'h0001, 16'h0000, 16'hFFFF};

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] seed;
      seed = 32'h1ACE_B00C;
      repeat (3) @(negedge clk);
      chk("R1 reset busy0", N'(busy0), '0);
      chk("R1 reset done1", N'(done1), '0);
      chk("R1 reset p0", p0, '0);
      chk("R1 reset p1", p1, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release busy1", N'(busy1), '0);
      chk("R1 after release done0", N'(done0), '0);
      chk("R1 after release p1", p1, '0);

      for (int v = 0; v < NV; v++) run(VA[v], VB[v], 1'b0);

      run(16'hC3A5, 16'h5A0F, 1'b1);

      for (int k = 0; k < 30; k++) begin
         logic [N-1:0] ra, rb;
         seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
         ra = seed[15:0];
         rb = seed[31:16];
         run(ra, rb, (k % 7) == 3);
      end

      summary();
      $finish;
   end

endmodule